// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Controller

This block sits behind a demodulated infrared receiver and records the shape of an incoming remote-control burst without decoding it. A programmable divider turns the system clock into a sampling tick. At each tick the receiver line is sampled and filtered so that short spikes are discarded. The block then counts how many ticks each mark and each space lasts. Every duration is an 8-bit sample count, and the counts are packed four to a word into a bank of capture words.

A space that runs to the 255-sample limit closes the message. The block then waits a programmable number of further idle ticks before it raises a status bit, which drives an interrupt line through an enable mask. From that point capture is frozen. Software reads the bank, clears the status and writes a restart bit. The restart zeroes the bank and re-arms the block to wait for the next mark. All control goes through a small word-addressed register interface with single-cycle write strobes and combinational read data.

Top module: `irw_capture`

## Requirements
- R1: After reset, CTRL (0x00) reads 0x000F0000, TICK (0x04) reads 2299, FILT (0x08) reads 0x00000100, IEN (0x10) and ISTAT (0x14) read 0, every capture word reads 0, and `irq` is low.
- R2: Each duration is the number of sampling ticks a level lasted. Durations are packed four per 32-bit capture word, with the earliest in bits 7:0 and later ones in bits 15:8, 23:16 and 31:24. Capture word i is read at address 0x40 + 4*i, for i from 0 to 16.
- R3: A mark is `ir_in` low. The block waits in an armed state until it sees a mark, so the first entry is always a mark and the later entries alternate space, mark, space and so on.
- R4: A mark longer than 255 ticks is recorded as 0xFF. A space that reaches 255 ticks ends the message and is recorded as 0xFF.
- R5: The bank holds 68 entries. Durations that arrive after the bank is full are dropped, and the message still ends on a 255-tick space.
- R6: After the ending space, the status bit (ISTAT bit 0) sets once CTRL bits 23:16 further ticks have passed.
- R7: A level change is accepted only after FILT bits 12:8 consecutive ticks of the new level, with a value of 0 treated as 1. Shorter excursions leave the filtered level unchanged and are not recorded.
- R8: Sampling and capture run only while both CTRL bit 0 (global enable) and CTRL bit 13 (width detection enable) are set.
- R9: Once a message has ended, further input activity leaves the capture words unchanged.
- R10: Writing 1 to bit 0 of RESTART (0x0C) zeroes all capture words and re-arms the block, which then waits for a mark.
- R11: `irq` equals the status bit ANDed with IEN bit 0. Writing 1 to ISTAT bit 0 clears the status bit.
- R12: The sampling tick fires once every TICK+1 clock cycles, so recorded widths count periods of TICK+1 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_in | input | 1 | Demodulated receiver line (mark is low), asynchronous |
| bus_wr | input | 1 | Single-cycle register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt request, status ANDed with enable |

## Verification
The hardest case to reach is a full bank. To fill it, a burst must carry more than 68 alternating levels, and every level must stay short of the 255-tick ending limit while the tick runs fast. The bench builds that burst arithmetically from a short period-of-five width pattern, so the expected bank is simply the first 68 computed widths with no terminator entry. The completion delay is bracketed by sampling `irq` a fixed number of ticks before and after the point where the idle threshold is crossed. The de-glitch filter is reached by blips shorter than the filter count, placed both in idle and inside marks and spaces.

// File: rtl/irw_pkg.sv
// Shared types and register offsets for the infrared width capture block.
// Assumes byte addressing with word-aligned registers.
package irw_pkg;
    typedef enum logic [1:0] {
        CAP_ARMED = 2'd0,
        CAP_RUN   = 2'd1,
        CAP_TAIL  = 2'd2,
        CAP_DONE  = 2'd3
    } cap_state_t;

    localparam int          WID_W        = 8;
    localparam logic [7:0]  WID_MAX      = 8'hFF;
    localparam logic [7:0]  WID_PRE_MAX  = 8'hFE;

    localparam logic [7:0]  ADDR_CTRL    = 8'h00;
    localparam logic [7:0]  ADDR_TICK    = 8'h04;
    localparam logic [7:0]  ADDR_FILT    = 8'h08;
    localparam logic [7:0]  ADDR_RESTART = 8'h0C;
    localparam logic [7:0]  ADDR_IEN     = 8'h10;
    localparam logic [7:0]  ADDR_ISTAT   = 8'h14;
    localparam logic [7:0]  ADDR_CAP     = 8'h40;
endpackage

// File: rtl/irw_tick_gen.sv
// Sampling tick divider: emits a one-cycle pulse every PERIOD+1 clocks.
// Assumes the period may change at any time; the count restarts when halted.
module irw_tick_gen #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] period,
    output logic          tick
);
    logic [PW-1:0] cnt_q;

    // Tick fires at the terminal count while running.
    assign tick = run && (cnt_q >= period);

    // Advance the divider, wrap on tick, hold at zero while halted.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PW'(1);
        end
    end
endmodule

// File: rtl/irw_deglitch.sv
// Input synchronizer and de-glitch filter.
// Samples the synchronized line at each tick; the filtered level flips only
// after NEED consecutive differing samples (0 is treated as 1).
// Assumes the line idles at IDLE_LEVEL.
module irw_deglitch #(
    parameter int   DG_W       = 5,
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            tick,
    input  logic            raw,
    input  logic [DG_W-1:0] need,
    output logic            level
);
    logic            sync1_q, sync2_q;
    logic [DG_W-1:0] diff_q;
    logic [DG_W:0]   diff_next;
    logic [DG_W:0]   need_eff;

    assign need_eff  = (need == '0) ? (DG_W+1)'(1) : {1'b0, need};
    assign diff_next = {1'b0, diff_q} + (DG_W+1)'(1);

    // Two-flop synchronizer for the asynchronous receiver line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= IDLE_LEVEL;
            sync2_q <= IDLE_LEVEL;
        end else begin
            sync1_q <= raw;
            sync2_q <= sync1_q;
        end
    end

    // Count consecutive differing samples and accept the change at NEED.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level  <= IDLE_LEVEL;
            diff_q <= '0;
        end else if (run && tick) begin
            if (sync2_q != level) begin
                if (diff_next >= need_eff) begin
                    level  <= sync2_q;
                    diff_q <= '0;
                end else begin
                    diff_q <= diff_next[DG_W-1:0];
                end
            end else begin
                diff_q <= '0;
            end
        end
    end
endmodule

// File: rtl/irw_width_fsm.sv
// Mark/space width measurement state machine.
// Armed -> waits for a mark; Run -> counts ticks per level and emits one store
// per completed level; a space reaching 255 stores 0xFF and enters Tail, which
// waits OK_COUNT further ticks before Done. Restart returns to Armed.
// Assumes 'mark' is the filtered level, already in mark polarity.
module irw_width_fsm
    import irw_pkg::*;
#(
    parameter int SLOTS = 68,
    parameter int IDX_W = 7,
    parameter int OK_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             restart,
    input  logic             mark,
    input  logic [OK_W-1:0]  ok_count,
    output logic             store_en,
    output logic [IDX_W-1:0] store_idx,
    output logic [WID_W-1:0] store_val,
    output logic             done_pulse,
    output cap_state_t       state,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(SLOTS);

    logic             phase_mark_q;
    logic [WID_W-1:0] cnt_q;
    logic [OK_W-1:0]  tail_q;
    logic             step, level_flip, space_sat, room;

    assign step       = run && tick;
    assign level_flip = (state == CAP_RUN) && (mark != phase_mark_q);
    assign space_sat  = (state == CAP_RUN) && !phase_mark_q && !level_flip
                        && (cnt_q == WID_PRE_MAX);
    assign room       = (idx < IDX_LIMIT);

    // One store per completed level while room remains.
    assign store_en  = step && room && (level_flip || space_sat);
    assign store_idx = idx;
    assign store_val = level_flip ? cnt_q : WID_MAX;

    // Sequence the capture phases and width counters.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            state        <= CAP_ARMED;
            phase_mark_q <= 1'b0;
            cnt_q        <= '0;
            tail_q       <= '0;
            idx          <= '0;
            done_pulse   <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            if (step) begin
                case (state)
                    CAP_ARMED: begin
                        if (mark) begin
                            state        <= CAP_RUN;
                            phase_mark_q <= 1'b1;
                            cnt_q        <= WID_W'(1);
                        end
                    end
                    CAP_RUN: begin
                        if (level_flip) begin
                            if (room) idx <= idx + IDX_W'(1);
                            phase_mark_q <= mark;
                            cnt_q        <= WID_W'(1);
                        end else if (space_sat) begin
                            if (room) idx <= idx + IDX_W'(1);
                            cnt_q  <= WID_MAX;
                            tail_q <= '0;
                            state  <= CAP_TAIL;
                        end else if (cnt_q != WID_MAX) begin
                            cnt_q <= cnt_q + WID_W'(1);
                        end
                    end
                    CAP_TAIL: begin
                        if (tail_q >= ok_count) begin
                            state      <= CAP_DONE;
                            done_pulse <= 1'b1;
                        end else begin
                            tail_q <= tail_q + OK_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/irw_capture_bank.sv
// Capture bank: WORDS words of LANES byte lanes, one byte written per store.
// Entry n lands in word n/LANES, lane n%LANES. Clear zeroes every lane.
module irw_capture_bank
    import irw_pkg::*;
#(
    parameter int WORDS = 17,
    parameter int LANES = 4,
    parameter int IDX_W = 7,
    localparam int BANK_W = WORDS * LANES * WID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             store_en,
    input  logic [IDX_W-1:0] store_idx,
    input  logic [WID_W-1:0] store_val,
    output logic [BANK_W-1:0] bank_flat
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            localparam logic [IDX_W-1:0] SLOT = IDX_W'(w * LANES + l);
            logic [WID_W-1:0] byte_q;

            // Hold one captured width; zero on reset or restart.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    byte_q <= '0;
                end else if (store_en && (store_idx == SLOT)) begin
                    byte_q <= store_val;
                end
            end

            assign bank_flat[(w*LANES + l)*WID_W +: WID_W] = byte_q;
        end
    end
endmodule

// File: rtl/irw_capture.sv
// Infrared pulse-width capture controller, top level.
// Holds the register file, interrupt status and read mux, and joins the tick
// divider, de-glitch filter, width state machine and capture bank.
// Assumes single-cycle write strobes; read data is combinational on address.
module irw_capture
    import irw_pkg::*;
#(
    parameter int          WORDS        = 17,
    parameter int          LANES        = 4,
    parameter int          TICK_W       = 16,
    parameter int          DG_W         = 5,
    parameter int          OK_W         = 8,
    parameter logic [15:0] TICK_DEFAULT = 16'd2299,
    parameter logic [7:0]  OK_DEFAULT   = 8'h0F,
    parameter logic [4:0]  DG_DEFAULT   = 5'd1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ir_in,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    localparam int SLOTS  = WORDS * LANES;
    localparam int IDX_W  = $clog2(SLOTS + 1);
    localparam int WORD_W = LANES * WID_W;
    localparam int BANK_W = WORDS * WORD_W;

    logic              gen_en_q, det_en_q, ien_q, stat_q;
    logic [OK_W-1:0]   ok_q;
    logic [TICK_W-1:0] period_q;
    logic [DG_W-1:0]   dg_q;

    logic              run, tick, level, done_pulse;
    logic              restart_wr, stat_clr_wr;
    logic              store_en;
    logic [IDX_W-1:0]  store_idx, cap_idx;
    logic [WID_W-1:0]  store_val;
    cap_state_t        cap_state;
    logic [BANK_W-1:0] bank_flat;
    logic [7:0]        cap_off;
    logic              unused_wdata;

    assign run         = gen_en_q && det_en_q;
    assign restart_wr  = bus_wr && (bus_addr == ADDR_RESTART) && bus_wdata[0];
    assign stat_clr_wr = bus_wr && (bus_addr == ADDR_ISTAT) && bus_wdata[0];
    assign unused_wdata = ^bus_wdata;

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_en_q <= 1'b0;
            det_en_q <= 1'b0;
            ok_q     <= OK_DEFAULT;
            period_q <= TICK_DEFAULT[TICK_W-1:0];
            dg_q     <= DG_DEFAULT[DG_W-1:0];
            ien_q    <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADDR_CTRL: begin
                    gen_en_q <= bus_wdata[0];
                    det_en_q <= bus_wdata[13];
                    ok_q     <= bus_wdata[16 +: OK_W];
                end
                ADDR_TICK: period_q <= bus_wdata[TICK_W-1:0];
                ADDR_FILT: dg_q     <= bus_wdata[8 +: DG_W];
                ADDR_IEN:  ien_q    <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    // Completion status: set by the state machine, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
        end else if (done_pulse) begin
            stat_q <= 1'b1;
        end else if (stat_clr_wr) begin
            stat_q <= 1'b0;
        end
    end

    assign irq = stat_q && ien_q;

    irw_tick_gen #(.PW(TICK_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .period (period_q),
        .tick   (tick)
    );

    irw_deglitch #(.DG_W(DG_W), .IDLE_LEVEL(1'b1)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick),
        .raw   (ir_in),
        .need  (dg_q),
        .level (level)
    );

    irw_width_fsm #(.SLOTS(SLOTS), .IDX_W(IDX_W), .OK_W(OK_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .tick       (tick),
        .restart    (restart_wr),
        .mark       (!level),
        .ok_count   (ok_q),
        .store_en   (store_en),
        .store_idx  (store_idx),
        .store_val  (store_val),
        .done_pulse (done_pulse),
        .state      (cap_state),
        .idx        (cap_idx)
    );

    irw_capture_bank #(.WORDS(WORDS), .LANES(LANES), .IDX_W(IDX_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (restart_wr),
        .store_en  (store_en),
        .store_idx (store_idx),
        .store_val (store_val),
        .bank_flat (bank_flat)
    );

    assign cap_off = bus_addr - ADDR_CAP;

    // Register read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL:  bus_rdata = 32'(gen_en_q) | (32'(det_en_q) << 13)
                                    | (32'(ok_q) << 16);
            ADDR_TICK:  bus_rdata = 32'(period_q);
            ADDR_FILT:  bus_rdata = 32'(dg_q) << 8;
            ADDR_IEN:   bus_rdata = 32'(ien_q);
            ADDR_ISTAT: bus_rdata = 32'(stat_q);
            default: begin
                if (bus_addr >= ADDR_CAP && (32'(cap_off) >> 2) < WORDS) begin
                    bus_rdata = 32'(bank_flat[32'(cap_off[7:2]) * WORD_W +: WORD_W]);
                end
            end
        endcase
    end
endmodule

// File: rtl/irw_checker.sv
// Assertion checker for irw_capture, attached by bind below.
module irw_checker
    import irw_pkg::*;
#(
    parameter int SLOTS  = 68,
    parameter int IDX_W  = 7,
    parameter int BANK_W = 544
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              store_en,
    input  logic [IDX_W-1:0]  cap_idx,
    input  cap_state_t        cap_state,
    input  logic [BANK_W-1:0] bank_flat,
    input  logic              restart_wr,
    input  logic              done_pulse,
    input  logic              stat_q,
    input  logic              ien_q,
    input  logic              irq
);
    AST_STORE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        store_en |-> tick);                                              // R12
    AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);                                                 // R8
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cap_idx <= IDX_W'(SLOTS));                                       // R5
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((cap_state == CAP_TAIL || cap_state == CAP_DONE) && !restart_wr)
        |=> $stable(bank_flat));                                         // R9
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart_wr |=> (bank_flat == '0) && (cap_state == CAP_ARMED));   // R10
    AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> stat_q);                                          // R6
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_q |-> !irq);                                                // R11
    AST_IRQ_NEEDS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stat_q);                                                 // R11
endmodule

bind irw_capture irw_checker #(
    .SLOTS  (SLOTS),
    .IDX_W  (IDX_W),
    .BANK_W (BANK_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .tick       (tick),
    .store_en   (store_en),
    .cap_idx    (cap_idx),
    .cap_state  (cap_state),
    .bank_flat  (bank_flat),
    .restart_wr (restart_wr),
    .done_pulse (done_pulse),
    .stat_q     (stat_q),
    .ien_q      (ien_q),
    .irq        (irq)
);

// File: tb/irw_capture_bench.sv
// Self-checking bench for irw_capture: arithmetic width patterns, computed
// expected bank contents, completion timing and control corner cases.
module irw_capture_bench;
    localparam int NW = 17;
    localparam int NS = 68;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_in = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;
    int P = 1;
    int exp_n = 0;
    logic [7:0] exp_b [NS];

    always #10 clk = ~clk;

    irw_capture u_irw_capture (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] expv);
        n_checks++;
        if (got !== expv) begin
            n_fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, expv);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * (P + 1)) @(negedge clk);
    endtask

    // Drive a level for n ticks; mark is ir_in low.
    task automatic send(input bit is_mark, input int n);
        @(negedge clk);
        ir_in = is_mark ? 1'b0 : 1'b1;
        repeat (n * (P + 1) - 1) @(negedge clk);
    endtask

    task automatic exp_clear();
        for (int i = 0; i < NS; i++) exp_b[i] = 8'h00;
        exp_n = 0;
    endtask

    task automatic exp_push(input int v);
        if (exp_n < NS) begin
            exp_b[exp_n] = (v > 255) ? 8'hFF : 8'(v);
            exp_n++;
        end
    endtask

    task automatic check_bank(input string tag);
        logic [31:0] d;
        for (int w = 0; w < NW; w++) begin
            rd(8'h40 + 8'(4 * w), d);
            check(tag, d, {exp_b[4*w+3], exp_b[4*w+2], exp_b[4*w+1], exp_b[4*w]});
        end
    endtask

    task automatic check_irq(input string tag, input logic expv);
        @(negedge clk);
        #1 check(tag, 32'(irq), 32'(expv));
    endtask

    // Long ending space: 255 ticks plus threshold plus margin.
    task automatic finish_msg(input int ok);
        send(1'b0, 255 + ok + 20);
        exp_push(255);
    endtask

    task automatic restart_all();
        wr(8'h14, 32'h1);
        wr(8'h0C, 32'h1);
    endtask

    localparam logic [31:0] CTRL_ON = 32'h0000_2001 | (32'd40 << 16);

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'h00, d); check("R1 ctrl", d, 32'h000F0000);
        rd(8'h04, d); check("R1 tick", d, 32'd2299);
        rd(8'h08, d); check("R1 filt", d, 32'h00000100);
        rd(8'h10, d); check("R1 ien", d, 32'h0);
        rd(8'h14, d); check("R1 istat", d, 32'h0);
        check_irq("R1 irq", 1'b0);
        exp_clear();
        check_bank("R1 bank");

        wr(8'h04, 32'd1); P = 1;
        wr(8'h10, 32'h1);
        wr(8'h00, CTRL_ON);
        rd(8'h00, d); check("R8 ctrl readback", d, CTRL_ON);

        // Message A: R2 packing, R3 alternation, R4 ending, R6 timing
        exp_clear();
        for (int n = 0; n < 21; n++) begin
            int v = 3 + (n * 7) % 11;
            send(n % 2 == 0, v);
            exp_push(v);
        end
        @(negedge clk); ir_in = 1'b1;
        wait_ticks(255 + 40 - 10);
        check_irq("R6 before threshold", 1'b0);
        wait_ticks(20);
        check_irq("R6 after threshold", 1'b1);
        rd(8'h14, d); check("R6 status", d, 32'h1);
        exp_push(255);
        check_bank("R2 R3 R4 message A");

        // R9: activity after completion is ignored
        send(1'b1, 10); send(1'b0, 10); send(1'b1, 10); send(1'b0, 300);
        check_bank("R9 frozen bank");

        // R11: mask and write-one-to-clear
        wr(8'h10, 32'h0);
        check_irq("R11 masked", 1'b0);
        rd(8'h14, d); check("R11 status kept", d, 32'h1);
        wr(8'h10, 32'h1);
        check_irq("R11 unmasked", 1'b1);
        wr(8'h14, 32'h1);
        check_irq("R11 cleared", 1'b0);
        rd(8'h14, d); check("R11 status cleared", d, 32'h0);

        // R10: restart zeroes the bank
        wr(8'h0C, 32'h1);
        exp_clear();
        check_bank("R10 cleared bank");

        // Message B: R5 overflow, 80 entries
        for (int n = 0; n < 80; n++) begin
            int v = 2 + (n % 5);
            send(n % 2 == 0, v);
            exp_push(v);
        end
        finish_msg(40);
        check_bank("R5 full bank");
        check_irq("R5 R6 completion when full", 1'b1);
        restart_all();

        // Message C: R4 saturated mark
        exp_clear();
        send(1'b1, 300); exp_push(300);
        send(1'b0, 20);  exp_push(20);
        send(1'b1, 5);   exp_push(5);
        finish_msg(40);
        check_bank("R4 saturation");
        restart_all();

        // Message D: R7 de-glitch with count 4
        wr(8'h08, 32'h0000_0400);
        exp_clear();
        send(1'b1, 2); send(1'b0, 10);
        rd(8'h40, d); check("R7 R3 idle glitch ignored", d, 32'h0);
        send(1'b1, 12); send(1'b0, 2); send(1'b1, 9); exp_push(23);
        send(1'b0, 7);  send(1'b1, 3); send(1'b0, 8); exp_push(18);
        send(1'b1, 6); exp_push(6);
        finish_msg(40);
        check_bank("R7 filtered widths");
        restart_all();
        wr(8'h08, 32'h0000_0100);

        // Message E: R12 slower tick, same widths
        wr(8'h04, 32'd3); P = 3;
        exp_clear();
        send(1'b1, 5); exp_push(5);
        send(1'b0, 9); exp_push(9);
        send(1'b1, 4); exp_push(4);
        finish_msg(40);
        check_bank("R12 period 3");
        restart_all();
        wr(8'h04, 32'd1); P = 1;

        // Message F: R8 both enables required
        exp_clear();
        wr(8'h00, 32'h0000_0001 | (32'd40 << 16));
        send(1'b1, 10); send(1'b0, 10); send(1'b1, 10); send(1'b0, 320);
        check_bank("R8 detect disabled");
        check_irq("R8 detect disabled irq", 1'b0);
        wr(8'h00, 32'h0000_2000 | (32'd40 << 16));
        send(1'b1, 10); send(1'b0, 10); send(1'b1, 10); send(1'b0, 320);
        check_bank("R8 global disabled");
        check_irq("R8 global disabled irq", 1'b0);
        wr(8'h00, CTRL_ON);
        send(1'b1, 7); exp_push(7);
        finish_msg(40);
        check_bank("R8 enabled");
        check_irq("R8 enabled irq", 1'b1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule